// File: doc/BRIEF.md
# Predicated Integer Execute Unit with Status Flags

This block is the integer execute stage of a 16-bit processor core. Each issued operation carries a 3-bit condition code that is tested against the incoming negative, zero and carry flags. The selected operation takes effect only when that test holds. The operation may be an add, subtract, compare, multiply, bitwise, shift, rotate or register move. When the test fails, the operation is silently dropped. Nothing is written, the flags pass through unchanged, and the hidden high-product register keeps its value.

A multiply returns the low half of the product as its result. The high half goes into an internal register, and only a dedicated move operation reads that register back. Signed and unsigned flavours of add, subtract, compare and multiply are separate opcodes. They differ in how the carry flag is formed. All outputs are registered, so results appear one clock after issue together with a valid strobe. The condition outcome is also exported for a neighbouring branch unit. A condition-only test opcode lets that unit use the full set of eight conditions.

Top module: `palu_top`

## Requirements
- R1: Conditions 0 to 3 mean: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry flag set. When the condition holds, the operation takes effect and `cond_pass_o` is 1 in the output cycle. Flags are packed as {N, Z, C} in bits [2:0].
- R2: Conditions 4 to 7 are honoured only by the test opcode (18). With any other opcode, a condition value of 4 or more suppresses the operation and `cond_pass_o` is 0.
- R3: A suppressed operation asserts no write, copies `flags_i` to `flags_o` even when `upd_i` is 1, and leaves `hi_o` unchanged.
- R4: Add (0) and subtract (2) set C on signed overflow. Unsigned add (1) sets C on carry out, and unsigned subtract (3) sets C on borrow. N is the result's top bit and Z marks a zero result.
- R5: Compare (4) and unsigned compare (5) never write. They always update the flags whatever `upd_i` is. Z means the operands are equal and N means a is less than b. For compare, C is signed overflow of a-b. For unsigned compare, C is the borrow.
- R6: Any other passing operation changes the flags only when `upd_i` is 1. Otherwise `flags_o` equals `flags_i`.
- R7: Multiply (6, signed) and unsigned multiply (7) write the low half of the product and load the high half into `hi_o`. C is set when the product does not fit in the low half. The high-read opcode (17) writes the current `hi_o`.
- R8: Shift left (12) and shift right (13) fill with zeros, and arithmetic shift right (14) fills with the sign bit. The amount is all of `b_i`, and an amount of 16 or more yields all fill bits.
- R9: Rotate right (15) moves the bits leaving the bottom into the top, using `b_i` modulo 16.
- R10: AND (8), OR (9), XOR (10), NOT of a (11) and move of b (16) write their result. When flags update, C is cleared and N and Z follow the result.
- R11: Reset clears all outputs. Results, write enable, flags, pass and `hi_o` appear on the clock edge after issue with `valid_o` high. An idle cycle (`in_valid_i` low) gives `valid_o` and `wr_en_o` low and leaves `hi_o` alone.
- R12: The test opcode (18) evaluates all eight conditions: 4 N and Z clear, 5 N clear, 6 N set, 7 N or Z set. It never writes and never changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | First operand (destination value) |
| b_i | input | 16 | Second operand or shift amount |
| cond_i | input | 3 | Condition code |
| upd_i | input | 1 | Request flag update |
| flags_i | input | 3 | Current flags {N, Z, C} |
| valid_o | output | 1 | Outputs belong to an issued operation |
| cond_pass_o | output | 1 | The condition held |
| wr_en_o | output | 1 | Write result to destination |
| result_o | output | 16 | Operation result |
| flags_o | output | 3 | Next flags {N, Z, C} |
| hi_o | output | 16 | High-product register |

## Verification
The bench builds the unit with its default 16-bit width. This gives a four-stage shifter, so every single-stage amount and combinations of stages are reachable. Amounts with bits above bit 3 exercise both the full-fill path of the shifts and the modulo behaviour of the rotate. At this width, hand-computable operands hit the signed-overflow boundary at 0x7FFF and the unsigned carry boundary at 0xFFFF. They also give multiply products whose high half is zero, all ones or neither, so both carry rules of the two multiplies are covered.

// File: rtl/palu_pkg.sv
`timescale 1ns/1ps
package palu_pkg;
   localparam int OP_W   = 5;
   localparam int CC_W   = 3;
   localparam int FLAG_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_UADD = 5'd1,
      OP_SUB  = 5'd2,
      OP_USUB = 5'd3,
      OP_CMP  = 5'd4,
      OP_UCMP = 5'd5,
      OP_MUL  = 5'd6,
      OP_UMUL = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_NOT  = 5'd11,
      OP_SHL  = 5'd12,
      OP_SHR  = 5'd13,
      OP_ASHR = 5'd14,
      OP_ROR  = 5'd15,
      OP_MOVR = 5'd16,
      OP_MFHI = 5'd17,
      OP_TEST = 5'd18
   } op_e;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2,
      SK_ROT   = 2'd3
   } shk_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
   } flags_t;

   function automatic logic op_writes(op_e op);
      case (op)
         OP_CMP, OP_UCMP, OP_TEST: return 1'b0;
         default:                  return (op <= OP_MFHI);
      endcase
   endfunction

   function automatic logic op_is_cmp(op_e op);
      return (op == OP_CMP) || (op == OP_UCMP);
   endfunction

   function automatic logic op_is_mul(op_e op);
      return (op == OP_MUL) || (op == OP_UMUL);
   endfunction
endpackage

// File: rtl/palu_cond.sv
`timescale 1ns/1ps
module palu_cond
   import palu_pkg::*;
(
   input  logic [CC_W-1:0] cond,
   input  flags_t          fl,
   input  logic            ext_ok,
   output logic            pass
);
   logic raw;

   always_comb begin
      case (cond)
         3'd0:    raw = 1'b1;
         3'd1:    raw = fl.zero;
         3'd2:    raw = !fl.zero;
         3'd3:    raw = fl.carry;
         3'd4:    raw = !fl.neg && !fl.zero;
         3'd5:    raw = !fl.neg;
         3'd6:    raw = fl.neg;
         default: raw = fl.neg || fl.zero;
      endcase
   end

   // extended conditions belong to the jump format only
   assign pass = raw && (ext_ok || !cond[CC_W-1]);
endmodule

// File: rtl/palu_shift.sv
`timescale 1ns/1ps
module palu_shift
   import palu_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic [DW-1:0] val,
   input  logic [DW-1:0] amt,
   input  shk_e          kind,
   output logic [DW-1:0] out
);
   localparam int SHW = $clog2(DW);

   generate
      if ((1 << SHW) != DW || DW < 4)
         $error("palu_shift: DW must be a power of two of at least 4");
   endgenerate

   logic          left, rot, fill, over;
   logic [DW-1:0] src, raw;
   logic [DW-1:0] st [SHW+1];

   assign left = (kind == SK_LEFT);
   assign rot  = (kind == SK_ROT);
   assign fill = (kind == SK_ARITH) && val[DW-1];
   assign over = |amt[DW-1:SHW];

   // left shifts run through the right shifter on a mirrored word
   for (genvar i = 0; i < DW; i++) begin : g_mirror
      assign src[i] = left ? val[DW-1-i] : val[i];
      assign out[i] = left ? raw[DW-1-i] : raw[i];
   end

   assign st[0] = src;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int S = 1 << k;
      assign st[k+1] = amt[k]
                       ? {(rot ? st[k][S-1:0] : {S{fill}}), st[k][DW-1:S]}
                       : st[k];
   end

   assign raw = (over && !rot) ? {DW{fill}} : st[SHW];
endmodule

// File: rtl/palu_datapath.sv
`timescale 1ns/1ps
module palu_datapath
   import palu_pkg::*;
#(
   parameter int DW = 16
)(
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] sh_res,
   input  logic [DW-1:0] hi_cur,
   output logic [DW-1:0] res,
   output flags_t        fl,
   output logic [DW-1:0] hi_new
);
   localparam int M  = DW - 1;
   localparam int PW = 2 * DW;

   logic [DW:0]   sum, dif;
   logic          add_ov, sub_ov, borrow;
   logic [PW-1:0] ps, pu;
   logic          c;

   assign sum    = {1'b0, a} + {1'b0, b};
   assign dif    = {1'b0, a} - {1'b0, b};
   assign borrow = dif[DW];
   assign add_ov = (a[M] == b[M]) && (sum[M] != a[M]);
   assign sub_ov = (a[M] != b[M]) && (dif[M] != a[M]);

   assign ps = $signed({{DW{a[M]}}, a}) * $signed({{DW{b[M]}}, b});
   assign pu = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

   always_comb begin
      res    = '0;
      c      = 1'b0;
      hi_new = '0;
      case (op)
         OP_ADD:  begin res = sum[M:0]; c = add_ov; end
         OP_UADD: begin res = sum[M:0]; c = sum[DW]; end
         OP_SUB,
         OP_CMP:  begin res = dif[M:0]; c = sub_ov; end
         OP_USUB,
         OP_UCMP: begin res = dif[M:0]; c = borrow; end
         OP_MUL: begin
            res    = ps[M:0];
            hi_new = ps[PW-1:DW];
            c      = (ps[PW-1:DW] != {DW{ps[M]}});
         end
         OP_UMUL: begin
            res    = pu[M:0];
            hi_new = pu[PW-1:DW];
            c      = (pu[PW-1:DW] != '0);
         end
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_SHL, OP_SHR, OP_ASHR, OP_ROR: res = sh_res;
         OP_MOVR: res = b;
         OP_MFHI: res = hi_cur;
         default: res = '0;
      endcase

      fl.carry = c;
      fl.zero  = (res == '0);
      case (op)
         OP_CMP:  fl.neg = dif[M] ^ sub_ov;
         OP_UCMP: fl.neg = borrow;
         default: fl.neg = res[M];
      endcase
   end
endmodule

// File: rtl/palu_top.sv
`timescale 1ns/1ps
module palu_top
   import palu_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid_i,
   input  logic [OP_W-1:0]       op_i,
   input  logic [DW-1:0]         a_i,
   input  logic [DW-1:0]         b_i,
   input  logic [CC_W-1:0]       cond_i,
   input  logic                  upd_i,
   input  logic [FLAG_W-1:0]     flags_i,
   output logic                  valid_o,
   output logic                  cond_pass_o,
   output logic                  wr_en_o,
   output logic [DW-1:0]         result_o,
   output logic [FLAG_W-1:0]     flags_o,
   output logic [DW-1:0]         hi_o
);
   op_e           op;
   flags_t        fl_in, dp_fl;
   logic          pass, go, flag_upd;
   shk_e          kind;
   logic [DW-1:0] sh_res, dp_res, dp_hi;

   assign op    = op_e'(op_i);
   assign fl_in = flags_t'(flags_i);

   palu_cond u_cond (
      .cond   (cond_i),
      .fl     (fl_in),
      .ext_ok (op == OP_TEST),
      .pass   (pass)
   );

   always_comb begin
      case (op)
         OP_SHL:  kind = SK_LEFT;
         OP_ASHR: kind = SK_ARITH;
         OP_ROR:  kind = SK_ROT;
         default: kind = SK_RIGHT;
      endcase
   end

   palu_shift #(.DW(DW)) u_shift (
      .val  (a_i),
      .amt  (b_i),
      .kind (kind),
      .out  (sh_res)
   );

   palu_datapath #(.DW(DW)) u_dp (
      .op     (op),
      .a      (a_i),
      .b      (b_i),
      .sh_res (sh_res),
      .hi_cur (hi_o),
      .res    (dp_res),
      .fl     (dp_fl),
      .hi_new (dp_hi)
   );

   assign go       = in_valid_i && pass;
   assign flag_upd = go && (op_is_cmp(op) || (upd_i && op_writes(op)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o     <= 1'b0;
         cond_pass_o <= 1'b0;
         wr_en_o     <= 1'b0;
         result_o    <= '0;
         flags_o     <= '0;
         hi_o        <= '0;
      end else begin
         valid_o     <= in_valid_i;
         cond_pass_o <= go;
         wr_en_o     <= go && op_writes(op);
         result_o    <= dp_res;
         flags_o     <= flag_upd ? dp_fl : flags_i;
         if (go && op_is_mul(op))
            hi_o <= dp_hi;
      end
   end

   assert_ext_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && cond_i[CC_W-1] && op != OP_TEST) |=> !cond_pass_o);

   assert_fail_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !pass) |=> (!wr_en_o && flags_o == $past(flags_i)));

   assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && op_is_mul(op)) |=> $stable(hi_o));

   assert_cmp_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op_is_cmp(op)) |=> !wr_en_o);

   assert_noupd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !upd_i && !op_is_cmp(op)) |=> flags_o == $past(flags_i));

   assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> (!valid_o && !wr_en_o));

   assert_test_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op == OP_TEST) |=> (!wr_en_o && flags_o == $past(flags_i)));
endmodule

// File: tb/tb_palu_top.sv
`timescale 1ns/1ps
module tb_palu_top;
   import palu_pkg::*;

   localparam int DW = 16;

   typedef struct packed {
      logic [4:0]  op;
      logic [15:0] a;
      logic [15:0] b;
      logic [2:0]  cond;
      logic        upd;
      logic [2:0]  fin;
      logic        we;
      logic [15:0] res;
      logic [2:0]  fl;
      logic        pass;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 40;
   // flags written as {N,Z,C}
   localparam vec_t VEC [NV] = '{
      '{OP_ADD,  16'h0005, 16'h0003, 3'd0, 1'b1, 3'b000, 1'b1, 16'h0008, 3'b000, 1'b1, 4'd4},  // R4
      '{OP_ADD,  16'h7FFF, 16'h0001, 3'd0, 1'b1, 3'b000, 1'b1, 16'h8000, 3'b101, 1'b1, 4'd4},  // R4
      '{OP_UADD, 16'hFFFF, 16'h0001, 3'd0, 1'b1, 3'b000, 1'b1, 16'h0000, 3'b011, 1'b1, 4'd4},  // R4
      '{OP_SUB,  16'h0003, 16'h0005, 3'd0, 1'b1, 3'b000, 1'b1, 16'hFFFE, 3'b100, 1'b1, 4'd4},  // R4
      '{OP_USUB, 16'h0003, 16'h0005, 3'd0, 1'b1, 3'b000, 1'b1, 16'hFFFE, 3'b101, 1'b1, 4'd4},  // R4
      '{OP_CMP,  16'hFFFF, 16'h0001, 3'd0, 1'b0, 3'b000, 1'b0, 16'h0000, 3'b100, 1'b1, 4'd5},  // R5
      '{OP_UCMP, 16'hFFFF, 16'h0001, 3'd0, 1'b0, 3'b111, 1'b0, 16'h0000, 3'b000, 1'b1, 4'd5},  // R5
      '{OP_CMP,  16'h1234, 16'h1234, 3'd0, 1'b0, 3'b101, 1'b0, 16'h0000, 3'b010, 1'b1, 4'd5},  // R5
      '{OP_AND,  16'hF0F0, 16'h0FF0, 3'd0, 1'b1, 3'b111, 1'b1, 16'h00F0, 3'b000, 1'b1, 4'd10}, // R10
      '{OP_OR,   16'hF000, 16'h000F, 3'd0, 1'b0, 3'b011, 1'b1, 16'hF00F, 3'b011, 1'b1, 4'd6},  // R6
      '{OP_XOR,  16'hAAAA, 16'hAAAA, 3'd0, 1'b1, 3'b001, 1'b1, 16'h0000, 3'b010, 1'b1, 4'd10}, // R10
      '{OP_NOT,  16'h0000, 16'h0000, 3'd0, 1'b1, 3'b000, 1'b1, 16'hFFFF, 3'b100, 1'b1, 4'd10}, // R10
      '{OP_MOVR, 16'h1111, 16'h8001, 3'd0, 1'b1, 3'b000, 1'b1, 16'h8001, 3'b100, 1'b1, 4'd10}, // R10
      '{OP_SHL,  16'h8001, 16'h0004, 3'd0, 1'b1, 3'b000, 1'b1, 16'h0010, 3'b000, 1'b1, 4'd8},  // R8
      '{OP_SHR,  16'h8001, 16'h0004, 3'd0, 1'b0, 3'b000, 1'b1, 16'h0800, 3'b000, 1'b1, 4'd8},  // R8
      '{OP_ASHR, 16'h8010, 16'h0004, 3'd0, 1'b1, 3'b000, 1'b1, 16'hF801, 3'b100, 1'b1, 4'd8},  // R8
      '{OP_ASHR, 16'h8000, 16'h0014, 3'd0, 1'b1, 3'b000, 1'b1, 16'hFFFF, 3'b100, 1'b1, 4'd8},  // R8
      '{OP_SHL,  16'hFFFF, 16'h0010, 3'd0, 1'b1, 3'b000, 1'b1, 16'h0000, 3'b010, 1'b1, 4'd8},  // R8
      '{OP_SHR,  16'h7FFF, 16'h0100, 3'd0, 1'b0, 3'b000, 1'b1, 16'h0000, 3'b000, 1'b1, 4'd8},  // R8
      '{OP_ROR,  16'h0001, 16'h0001, 3'd0, 1'b0, 3'b000, 1'b1, 16'h8000, 3'b000, 1'b1, 4'd9},  // R9
      '{OP_ROR,  16'h1234, 16'h0014, 3'd0, 1'b0, 3'b000, 1'b1, 16'h4123, 3'b000, 1'b1, 4'd9},  // R9
      '{OP_ROR,  16'h00F1, 16'h0010, 3'd0, 1'b0, 3'b000, 1'b1, 16'h00F1, 3'b000, 1'b1, 4'd9},  // R9
      '{OP_ADD,  16'h0001, 16'h0001, 3'd1, 1'b0, 3'b010, 1'b1, 16'h0002, 3'b010, 1'b1, 4'd1},  // R1
      '{OP_ADD,  16'h0001, 16'h0001, 3'd1, 1'b0, 3'b000, 1'b0, 16'h0000, 3'b000, 1'b0, 4'd1},  // R1
      '{OP_ADD,  16'h0001, 16'h0001, 3'd2, 1'b0, 3'b000, 1'b1, 16'h0002, 3'b000, 1'b1, 4'd1},  // R1
      '{OP_ADD,  16'h0001, 16'h0001, 3'd2, 1'b1, 3'b010, 1'b0, 16'h0000, 3'b010, 1'b0, 4'd3},  // R3
      '{OP_ADD,  16'h0001, 16'h0001, 3'd3, 1'b1, 3'b001, 1'b1, 16'h0002, 3'b000, 1'b1, 4'd1},  // R1
      '{OP_ADD,  16'h0001, 16'h0001, 3'd3, 1'b1, 3'b110, 1'b0, 16'h0000, 3'b110, 1'b0, 4'd3},  // R3
      '{OP_ADD,  16'h0001, 16'h0001, 3'd5, 1'b1, 3'b000, 1'b0, 16'h0000, 3'b000, 1'b0, 4'd2},  // R2
      '{OP_XOR,  16'h00FF, 16'h0F00, 3'd7, 1'b1, 3'b010, 1'b0, 16'h0000, 3'b010, 1'b0, 4'd2},  // R2
      '{OP_TEST, 16'h0000, 16'h0000, 3'd4, 1'b0, 3'b000, 1'b0, 16'h0000, 3'b000, 1'b1, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd4, 1'b0, 3'b010, 1'b0, 16'h0000, 3'b010, 1'b0, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd5, 1'b0, 3'b001, 1'b0, 16'h0000, 3'b001, 1'b1, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd6, 1'b0, 3'b100, 1'b0, 16'h0000, 3'b100, 1'b1, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd6, 1'b0, 3'b000, 1'b0, 16'h0000, 3'b000, 1'b0, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd7, 1'b0, 3'b010, 1'b0, 16'h0000, 3'b010, 1'b1, 4'd12}, // R12
      '{OP_TEST, 16'h0000, 16'h0000, 3'd7, 1'b0, 3'b000, 1'b0, 16'h0000, 3'b000, 1'b0, 4'd12}, // R12
      '{OP_TEST, 16'h0005, 16'h0003, 3'd0, 1'b1, 3'b111, 1'b0, 16'h0000, 3'b111, 1'b1, 4'd12}, // R12
      '{OP_MUL,  16'hFFFE, 16'h0003, 3'd0, 1'b1, 3'b000, 1'b1, 16'hFFFA, 3'b100, 1'b1, 4'd7},  // R7
      '{OP_UMUL, 16'h0100, 16'h0100, 3'd0, 1'b1, 3'b000, 1'b1, 16'h0000, 3'b011, 1'b1, 4'd7}   // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [4:0]  op_i = '0;
   logic [15:0] a_i = '0, b_i = '0;
   logic [2:0]  cond_i = '0;
   logic        upd_i = 1'b0;
   logic [2:0]  flags_i = '0;
   logic        valid_o, cond_pass_o, wr_en_o;
   logic [15:0] result_o, hi_o;
   logic [2:0]  flags_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 8 ns period

   palu_top #(.DW(DW)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid_i),
      .op_i        (op_i),
      .a_i         (a_i),
      .b_i         (b_i),
      .cond_i      (cond_i),
      .upd_i       (upd_i),
      .flags_i     (flags_i),
      .valid_o     (valid_o),
      .cond_pass_o (cond_pass_o),
      .wr_en_o     (wr_en_o),
      .result_o    (result_o),
      .flags_o     (flags_o),
      .hi_o        (hi_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic [2:0] cond, input logic upd, input logic [2:0] fin);
      in_valid_i = 1'b1;
      op_i       = op;
      a_i        = a;
      b_i        = b;
      cond_i     = cond;
      upd_i      = upd;
      flags_i    = fin;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      chk("R11", "valid",  valid_o, 0);
      chk("R11", "wr_en",  wr_en_o, 0);
      chk("R11", "flags",  flags_o, 0);
      chk("R11", "hi",     hi_o, 0);
      chk("R11", "result", result_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: one-cycle latency and strobe
      in_valid_i = 1'b1; op_i = OP_ADD; a_i = 16'd5; b_i = 16'd3;
      cond_i = 3'd0; upd_i = 1'b0; flags_i = 3'b000;
      #1;
      chk("R11", "valid before edge", valid_o, 0);
      @(negedge clk);
      chk("R11", "valid after edge", valid_o, 1);
      chk("R11", "result after edge", result_o, 16'h0008);
      in_valid_i = 1'b0;
      @(negedge clk);
      chk("R11", "valid idle", valid_o, 0);
      chk("R11", "wr_en idle", wr_en_o, 0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
         issue(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].cond, VEC[i].upd, VEC[i].fin);
         chk(tag, "pass",  cond_pass_o, VEC[i].pass);
         chk(tag, "wr_en", wr_en_o, VEC[i].we);
         chk(tag, "flags", flags_o, VEC[i].fl);
         if (VEC[i].we)
            chk(tag, "result", result_o, VEC[i].res);
      end

      // R7: high half of last unsigned multiply, then read back
      chk("R7", "hi after umul", hi_o, 16'h0001);
      issue(OP_MFHI, 16'h0000, 16'h0000, 3'd0, 1'b1, 3'b111);
      chk("R7", "mfhi result", result_o, 16'h0001);
      chk("R7", "mfhi flags",  flags_o, 3'b000);
      chk("R7", "mfhi wr_en",  wr_en_o, 1);

      // R3: failed multiply leaves hi alone
      issue(OP_MUL, 16'h7FFF, 16'h7FFF, 3'd1, 1'b1, 3'b000);
      chk("R3", "failed mul wr_en", wr_en_o, 0);
      chk("R3", "failed mul hi",    hi_o, 16'h0001);

      // R7: signed product overflowing the low half
      issue(OP_MUL, 16'h7FFF, 16'h7FFF, 3'd0, 1'b1, 3'b000);
      chk("R7", "big mul result", result_o, 16'h0001);
      chk("R7", "big mul flags",  flags_o, 3'b001);
      chk("R7", "big mul hi",     hi_o, 16'h3FFF);

      // R11: idle cycle with a multiply on the inputs does nothing
      in_valid_i = 1'b0; op_i = OP_MUL; a_i = 16'd2; b_i = 16'd2; upd_i = 1'b1;
      @(negedge clk);
      chk("R11", "idle mul valid", valid_o, 0);
      chk("R11", "idle mul wr_en", wr_en_o, 0);
      chk("R11", "idle mul hi",    hi_o, 16'h3FFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule